// File: doc/BRIEF.md
# Dirty Victim Miss Transaction Sequencer

This block takes a cache miss and turns it into the system transactions that resolve it. A miss event arrives with the requested address, the cache index and a flag saying whether the line being evicted was modified. The block always sends a coherent read first. In that read packet it sets a dirty-victim-pending bit when the evicted line was modified. When the victim was dirty, a writeback to the same cache index follows the read. The block then waits for a completion on each transaction that it issued. The two completions may arrive in either order.

Both the miss input and the transaction output are valid/ready streams. A miss is accepted on a cycle where `miss_valid` and `miss_ready` are both high. `miss_ready` stays low from that cycle until every transaction of the pair has completed. On the output, a transaction is handed over on a cycle where `txn_valid` and `txn_ready` are both high. While `txn_valid` is high and `txn_ready` is low, the presented transaction is held unchanged, so the consumer may stall it for any number of cycles. The completion pulses and the error flag are plain control pins. A completion for a transaction that is not outstanding sets a sticky error flag, which only reset clears.

Top module: `dvp_miss_seq`

## Requirements
- R1: Out of reset, `miss_ready`=1, `txn_valid`=0 and `err`=0. After a miss is accepted, `miss_ready` is 0 until the pair has completed.
- R2: In the cycle after a miss is accepted, a read is presented. It has `txn_kind`=0, `txn_addr` equal to the miss address, `txn_index` equal to the miss index, and `txn_dvp` equal to the miss dirty flag.
- R3: When the victim was dirty, the cycle after the read handshake presents a writeback. It has `txn_kind`=1, the same `txn_index` as the read, `txn_dvp`=0 and `txn_addr`=0.
- R4: When the victim was clean, only the read is issued. `txn_valid` is 0 after the read handshake.
- R5: While `txn_valid`=1 and `txn_ready`=0, the transaction kind, address, index and `txn_dvp` stay unchanged and `txn_valid` stays 1.
- R6: The read and writeback completions are accepted in either order, in the same cycle, or with the read completing before the writeback has been handed over. `miss_ready` returns to 1 two cycles after the cycle in which the last completion pulse is driven. It stays 0 while any completion is missing.
- R7: A `rd_done` or `wb_done` pulse for a transaction that is not outstanding sets `err` to 1. `err` stays 1 until reset. The pulse does not otherwise change the sequencing.
- R8: A writeback is handed over only after its paired read has been handed over. At most one writeback is handed over per miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss event valid |
| miss_ready | output | 1 | Block can accept a miss |
| miss_addr | input | AW | Address of the missed line |
| miss_index | input | IW | Cache index of the miss |
| miss_dirty | input | 1 | Evicted line was modified |
| txn_valid | output | 1 | Transaction presented |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_kind | output | 1 | 0 = coherent read, 1 = writeback |
| txn_addr | output | AW | Read address (0 for writeback) |
| txn_index | output | IW | Cache index of the transaction |
| txn_dvp | output | 1 | Dirty-victim-pending bit (reads only) |
| rd_done | input | 1 | Read completion pulse |
| wb_done | input | 1 | Writeback completion pulse |
| err | output | 1 | Sticky flag for a completion with nothing outstanding |

## Verification
The hardest case to reach is a read completion that arrives while the paired writeback is still being stalled at the output. The block then has one transaction finished and the other not yet issued. The bench reaches this case by holding `txn_ready` low after the read handshake and pulsing `rd_done` during the stall. It runs this case, together with the read-first, writeback-first and simultaneous completion orders, for every combination of victim state and stall length from zero to two cycles. A separate step drives a duplicate read completion during the wait, to check that the error flag is raised without disturbing the pair.

// File: rtl/dvp_seq_pkg.sv
package dvp_seq_pkg;
  typedef enum logic {
    KIND_READ = 1'b0,
    KIND_WB   = 1'b1
  } txn_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WB   = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dvp_issue_seq.sv
module dvp_issue_seq
  import dvp_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  output logic          miss_ready,
  input  logic [AW-1:0] miss_addr,
  input  logic [IW-1:0] miss_index,
  input  logic          miss_dirty,
  output logic          txn_valid,
  input  logic          txn_ready,
  output logic          txn_kind,
  output logic [AW-1:0] txn_addr,
  output logic [IW-1:0] txn_index,
  output logic          txn_dvp,
  input  logic          all_clear,
  output logic          pair_start,
  output logic          rd_fire,
  output logic          wb_fire
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] index_q;
  logic          dirty_q;

  assign miss_ready = (state_q == ST_IDLE);
  assign pair_start = miss_valid && miss_ready;
  assign txn_valid  = (state_q == ST_RD) || (state_q == ST_WB);
  assign txn_kind   = (state_q == ST_WB) ? KIND_WB : KIND_READ;
  assign txn_addr   = (state_q == ST_RD) ? addr_q : '0;
  assign txn_index  = index_q;
  assign txn_dvp    = (state_q == ST_RD) && dirty_q;
  assign rd_fire    = (state_q == ST_RD) && txn_ready;
  assign wb_fire    = (state_q == ST_WB) && txn_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (pair_start) state_d = ST_RD;
      ST_RD:   if (txn_ready) state_d = dirty_q ? ST_WB : ST_WAIT;
      ST_WB:   if (txn_ready) state_d = ST_WAIT;
      ST_WAIT: if (all_clear) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      index_q <= '0;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pair_start) begin
        addr_q  <= miss_addr;
        index_q <= miss_index;
        dirty_q <= miss_dirty;
      end
    end
  end

  AST_TXN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable({txn_kind, txn_addr, txn_index, txn_dvp}))); // R5
endmodule

// File: rtl/dvp_cpl_track.sv
module dvp_cpl_track (
  input  logic clk,
  input  logic rst_n,
  input  logic pair_start,
  input  logic rd_fire,
  input  logic wb_fire,
  input  logic rd_done,
  input  logic wb_done,
  output logic rd_out,
  output logic wb_out,
  output logic rd_issued,
  output logic wb_issued,
  output logic all_clear,
  output logic err
);
  logic rd_bad, wb_bad;

  assign rd_bad    = rd_done && !rd_out;
  assign wb_bad    = wb_done && !wb_out;
  assign all_clear = !rd_out && !wb_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_out    <= 1'b0;
      wb_out    <= 1'b0;
      rd_issued <= 1'b0;
      wb_issued <= 1'b0;
      err       <= 1'b0;
    end else begin
      if (rd_fire) rd_out <= 1'b1;
      else if (rd_done && rd_out) rd_out <= 1'b0;
      if (wb_fire) wb_out <= 1'b1;
      else if (wb_done && wb_out) wb_out <= 1'b0;
      if (pair_start) begin
        rd_issued <= 1'b0;
        wb_issued <= 1'b0;
      end else begin
        if (rd_fire) rd_issued <= 1'b1;
        if (wb_fire) wb_issued <= 1'b1;
      end
      if (rd_bad || wb_bad) err <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R7
  AST_WB_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> rd_issued); // R8
  AST_ONE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> !wb_issued); // R8
endmodule

// File: rtl/dvp_miss_seq.sv
module dvp_miss_seq #(
  parameter int AW = 16,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  output logic          miss_ready,
  input  logic [AW-1:0] miss_addr,
  input  logic [IW-1:0] miss_index,
  input  logic          miss_dirty,
  output logic          txn_valid,
  input  logic          txn_ready,
  output logic          txn_kind,
  output logic [AW-1:0] txn_addr,
  output logic [IW-1:0] txn_index,
  output logic          txn_dvp,
  input  logic          rd_done,
  input  logic          wb_done,
  output logic          err
);
  logic all_clear, pair_start, rd_fire, wb_fire;
  logic rd_out, wb_out, rd_issued, wb_issued;

  dvp_issue_seq #(.AW(AW), .IW(IW)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_index(miss_index), .miss_dirty(miss_dirty),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_kind(txn_kind),
    .txn_addr(txn_addr), .txn_index(txn_index), .txn_dvp(txn_dvp),
    .all_clear(all_clear), .pair_start(pair_start),
    .rd_fire(rd_fire), .wb_fire(wb_fire)
  );

  dvp_cpl_track u_track (
    .clk(clk), .rst_n(rst_n), .pair_start(pair_start),
    .rd_fire(rd_fire), .wb_fire(wb_fire),
    .rd_done(rd_done), .wb_done(wb_done),
    .rd_out(rd_out), .wb_out(wb_out),
    .rd_issued(rd_issued), .wb_issued(wb_issued),
    .all_clear(all_clear), .err(err)
  );

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> (!rd_out && !wb_out && !txn_valid)); // R1
  AST_DVP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_kind) |-> !txn_dvp); // R3
endmodule

// File: tb/dvp_miss_seq_tb.sv
module dvp_miss_seq_tb;
  localparam int AW = 16;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic miss_ready;
  logic [AW-1:0] miss_addr = '0;
  logic [IW-1:0] miss_index = '0;
  logic miss_dirty = 1'b0;
  logic txn_valid;
  logic txn_ready = 1'b0;
  logic txn_kind;
  logic [AW-1:0] txn_addr;
  logic [IW-1:0] txn_index;
  logic txn_dvp;
  logic rd_done = 1'b0;
  logic wb_done = 1'b0;
  logic err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dvp_miss_seq #(.AW(AW), .IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_index(miss_index), .miss_dirty(miss_dirty),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_kind(txn_kind),
    .txn_addr(txn_addr), .txn_index(txn_index), .txn_dvp(txn_dvp),
    .rd_done(rd_done), .wb_done(wb_done), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic r, input logic w);
    rd_done = r;
    wb_done = w;
    @(negedge clk);
    rd_done = 1'b0;
    wb_done = 1'b0;
  endtask

  task automatic hold_check(input logic k, input logic [AW-1:0] a);
    chk("R5 valid held", 32'(txn_valid), 32'd1);
    chk("R5 kind held", 32'(txn_kind), 32'(k));
    chk("R5 addr held", 32'(txn_addr), 32'(a));
  endtask

  // order: 0 rd then wb, 1 wb then rd, 2 together, 3 rd during wb stall, 5 duplicate rd
  task automatic run_miss(input logic [AW-1:0] a, input logic [IW-1:0] ix,
                          input logic d, input int stall, input int order);
    @(negedge clk);
    chk("R1 ready idle", 32'(miss_ready), 32'd1);
    miss_valid = 1'b1; miss_addr = a; miss_index = ix; miss_dirty = d;
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R1 busy", 32'(miss_ready), 32'd0);
    chk("R2 valid", 32'(txn_valid), 32'd1);
    chk("R2 kind", 32'(txn_kind), 32'd0);
    chk("R2 addr", 32'(txn_addr), 32'(a));
    chk("R2 index", 32'(txn_index), 32'(ix));
    chk("R2 dvp", 32'(txn_dvp), 32'(d));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      hold_check(1'b0, a);
      chk("R5 dvp held", 32'(txn_dvp), 32'(d));
    end
    txn_ready = 1'b1;
    @(negedge clk);
    txn_ready = 1'b0;
    if (d) begin
      chk("R3 valid", 32'(txn_valid), 32'd1);
      chk("R3 kind", 32'(txn_kind), 32'd1);
      chk("R3 index", 32'(txn_index), 32'(ix));
      chk("R3 dvp", 32'(txn_dvp), 32'd0);
      chk("R3 addr", 32'(txn_addr), 32'd0);
      if (order == 3) begin
        pulse(1'b1, 1'b0);
        hold_check(1'b1, '0);
      end
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        hold_check(1'b1, '0);
      end
      txn_ready = 1'b1;
      @(negedge clk);
      txn_ready = 1'b0;
      chk("R8 single wb", 32'(txn_valid), 32'd0);
      case (order)
        0: begin pulse(1'b1, 1'b0); chk("R6 wait wb", 32'(miss_ready), 32'd0); pulse(1'b0, 1'b1); end
        1: begin pulse(1'b0, 1'b1); chk("R6 wait rd", 32'(miss_ready), 32'd0); pulse(1'b1, 1'b0); end
        2: pulse(1'b1, 1'b1);
        3: pulse(1'b0, 1'b1);
        default: begin
          pulse(1'b1, 1'b0);
          pulse(1'b1, 1'b0);
          chk("R7 dup rd err", 32'(err), 32'd1);
          chk("R7 still waiting", 32'(miss_ready), 32'd0);
          pulse(1'b0, 1'b1);
        end
      endcase
    end else begin
      chk("R4 no wb", 32'(txn_valid), 32'd0);
      pulse(1'b1, 1'b0);
    end
    chk("R6 not yet ready", 32'(miss_ready), 32'd0);
    @(negedge clk);
    chk("R6 ready after pair", 32'(miss_ready), 32'd1);
    chk("R7 err state", 32'(err), (order == 5) ? 32'd1 : 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 32'(miss_ready), 32'd1);
    chk("R1 reset valid", 32'(txn_valid), 32'd0);
    chk("R1 reset err", 32'(err), 32'd0);
    rst_n = 1'b1;
    for (int d = 0; d < 2; d++)
      for (int st = 0; st < 3; st++)
        for (int o = 0; o < 4; o++)
          if (d == 1 || o == 0)
            run_miss(AW'(16'h1000 + d * 256 + st * 16 + o), IW'(d * 12 + st * 4 + o + 1), d[0], st, o);
    // R7: spurious writeback completion while idle
    @(negedge clk);
    pulse(1'b0, 1'b1);
    chk("R7 spurious err", 32'(err), 32'd1);
    chk("R7 still idle", 32'(miss_ready), 32'd1);
    pulse(1'b1, 1'b0);
    chk("R7 sticky", 32'(err), 32'd1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset clears err", 32'(err), 32'd0);
    rst_n = 1'b1;
    run_miss(16'hBEEF, 6'h2A, 1'b1, 1, 5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule